// File: doc/BRIEF.md
# Loopback UART Register Model

This block presents eight byte-wide registers that act like a classic 16550-style UART, but it has no serial line. Each byte the host writes to the data register goes into an internal circular buffer. Reading the data register takes the bytes back out in the order they went in. The host uses a single-cycle synchronous register bus: a 3-bit offset, a write strobe, a read strobe, write data and registered read data. A one-cycle interrupt pulse tells the host when an interrupting event has occurred.

The line status, modem status and interrupt identification values are built from three things: the buffer's fill level, a sticky overrun flag, and the contents of the control registers. Software written for a real UART can therefore run its usual probe, divisor setup, FIFO setup and interrupt handling code against this block. Baud generation, shifting, parity, framing and break are not modelled.

Read data appears on `reg_rdata` in the cycle after the read strobe and holds until the next accepted read. The interrupt pulse appears in the cycle after the access that caused it.

Top module: `lpbk_uart`

## Requirements
- R1: After reset, `reg_rdata` is 0x00 and `irq_pulse` is 0. The buffer is empty, the FIFO is enabled with 16 entries, the trigger level is 1, and all control registers are zero.
- R2: Bytes written at offset 0 are read back at offset 0 in first-in first-out order. The buffer holds up to 16 bytes, and its indices wrap around.
- R3: Writing offset 3 with bit 7 set clears the 16-bit divisor. While offset 3 bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. In that state the buffer and the interrupt enables are left untouched.
- R4: A push while the buffer is at capacity is dropped and sets the overrun flag. Any accepted push clears the overrun flag. Pops do not clear it.
- R5: An offset 2 write with bit 1 or bit 2 set empties the buffer. Bit 0 of the same write sets the capacity: 16 entries when set, 1 entry when clear.
- R6: Offset 2 write bits 7:6 set the data-available trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With bit 0 clear, the trigger level is 1.
- R7: Offset 5 reads 0x01 while the buffer is non-empty and 0x60 while it is empty, with bit 1 added while overrun is set. Writes to offsets 5 and 6 have no effect.
- R8: Offset 6 reads 0xB3. It reads 0xA2 instead when offset 4 bit 5 is set and the buffer is at capacity.
- R9: Offset 1 reads return only the low four bits of the enable byte. Offsets 3, 4 and 7 read back the last value written to them.
- R10: Offset 2 reads return 0xC0 OR'ed with a code for the highest-priority pending source. The sources, highest first, are:
  - overrun with enable bit 2 set gives code 0x6;
  - buffer count at or above the trigger level with enable bit 0 set gives 0x4;
  - buffer empty with enable bit 1 set gives 0x2;
  - offset 4 bit 0 or bit 1 set with enable bit 3 set gives 0x0.
  
  With no source pending, the code is 0x1.
- R11: `irq_pulse` is high for one cycle after each of these events:
  - a push makes the count equal the trigger level while enable bit 0 is set;
  - a push is dropped while enable bit 2 is set;
  - an enable write sets bit 1 while the buffer is empty;
  - a pop empties the buffer while enable bit 1 is set;
  - an offset 4 write sets bit 0, 1 or 3 while enable bit 3 is set.
- R12: Reading offset 0 while the buffer is empty returns the last byte popped (0x00 after reset) and changes no state.
- R13: When `reg_wr` and `reg_rd` are both high in the same cycle, only the write takes effect, and `reg_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_pulse | output | 1 | One-cycle interrupt event |

## Verification
The hardest state to reach is the one where several interrupt sources are pending together, so that the priority order in the identification code can be seen. The stimulus gets there by first switching the FIFO to single-entry mode, which makes one push fill the buffer. A second push then overflows, so overrun, data-available and the empty-buffer condition can be set up and released one at a time with a few accesses. The buffer wrap-around is reached in a similar way: a short burst first moves the indices off zero, and then a full 16-byte fill and drain crosses the boundary.

// File: rtl/lpbk_uart_pkg.sv
package lpbk_uart_pkg;

  localparam int BYTE_W = 8;

  localparam logic [2:0] OFS_DATA    = 3'd0;
  localparam logic [2:0] OFS_IEN     = 3'd1;
  localparam logic [2:0] OFS_FCTL    = 3'd2;
  localparam logic [2:0] OFS_LCTL    = 3'd3;
  localparam logic [2:0] OFS_MCTL    = 3'd4;
  localparam logic [2:0] OFS_LSTAT   = 3'd5;
  localparam logic [2:0] OFS_MSTAT   = 3'd6;
  localparam logic [2:0] OFS_SCRATCH = 3'd7;

  // enable bit positions
  localparam int IEN_DATA  = 0;
  localparam int IEN_EMPTY = 1;
  localparam int IEN_LINE  = 2;
  localparam int IEN_MODEM = 3;

  // data-available trigger level from the select field
  function automatic logic [7:0] trig_from_sel(input logic [1:0] sel, input logic fifo_on);
    logic [7:0] lvl;
    case (sel)
      2'b00:   lvl = 8'd1;
      2'b01:   lvl = 8'd4;
      2'b10:   lvl = 8'd8;
      default: lvl = 8'd14;
    endcase
    return fifo_on ? lvl : 8'd1;
  endfunction

  // highest-priority source code, 4'h1 when idle
  function automatic logic [3:0] iir_code(input logic ls, input logic da,
                                          input logic te, input logic ms);
    if (ls)      return 4'h6;
    else if (da) return 4'h4;
    else if (te) return 4'h2;
    else if (ms) return 4'h0;
    else         return 4'h1;
  endfunction

  function automatic logic [7:0] lsr_pack(input logic has_data, input logic ovr);
    return {1'b0, !has_data, !has_data, 3'b000, ovr, has_data};
  endfunction

  function automatic logic [7:0] msr_pack(input logic cts);
    return {1'b1, 1'b0, 1'b1, cts, 2'b00, 1'b1, cts};
  endfunction

endpackage

// File: rtl/lpbk_ring.sv
module lpbk_ring #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              clr,
  input  logic              cap_one,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              at_cap,
  output logic              push_ok,
  output logic              push_drop,
  output logic              pop_ok,
  output logic              ovr
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head, tail;

  assign empty     = (count == '0);
  assign at_cap    = cap_one ? !empty : (count == CNT_W'(DEPTH));
  assign push_ok   = push_req && !at_cap;
  assign push_drop = push_req && at_cap;
  assign pop_ok    = pop_req && !empty;
  assign dout      = mem[tail];

  always_ff @(posedge clk) begin
    if (push_ok) mem[head] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (clr) begin
        head  <= '0;
        tail  <= '0;
        count <= '0;
      end else begin
        if (push_ok) head <= head + 1'b1;
        if (pop_ok)  tail <= tail + 1'b1;
        if (push_ok && !pop_ok)      count <= count + 1'b1;
        else if (pop_ok && !push_ok) count <= count - 1'b1;
      end
      if (push_drop)    ovr <= 1'b1;
      else if (push_ok) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/lpbk_ctl_regs.sv
module lpbk_ctl_regs
  import lpbk_uart_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [3:0]  ier,
  output logic [7:0]  lcr,
  output logic [7:0]  mcr,
  output logic [7:0]  scr,
  output logic [15:0] divisor,
  output logic        fifo_on,
  output logic [7:0]  trig_lvl,
  output logic        dlab,
  output logic        clr_req
);
  assign dlab    = lcr[7];
  assign clr_req = wr_en && (addr == OFS_FCTL) && (wdata[1] || wdata[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier      <= '0;
      lcr      <= '0;
      mcr      <= '0;
      scr      <= '0;
      divisor  <= '0;
      fifo_on  <= 1'b1;
      trig_lvl <= 8'd1;
    end else if (wr_en) begin
      case (addr)
        OFS_DATA: if (dlab) divisor[7:0] <= wdata;
        OFS_IEN: begin
          if (dlab) divisor[15:8] <= wdata;
          else      ier <= wdata[3:0];
        end
        OFS_FCTL: begin
          fifo_on  <= wdata[0];
          trig_lvl <= trig_from_sel(wdata[7:6], wdata[0]);
        end
        OFS_LCTL: begin
          lcr <= wdata;
          if (wdata[7]) divisor <= '0;
        end
        OFS_MCTL:    mcr <= wdata;
        OFS_SCRATCH: scr <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lpbk_irq_gen.sv
module lpbk_irq_gen
  import lpbk_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier,
  input  logic [1:0] mcr_lines,
  input  logic [7:0] cnt8,
  input  logic [7:0] trig_lvl,
  input  logic       empty,
  input  logic       ovr,
  input  logic       push_ok,
  input  logic       push_drop,
  input  logic       pop_ok,
  input  logic       ier_wr,
  input  logic       mcr_wr,
  input  logic [7:0] wdata,
  output logic [7:0] iir_val,
  output logic       irq_pulse
);
  logic ev_data, ev_line, ev_en_empty, ev_drain, ev_modem, ev_any;
  logic src_line, src_data, src_empty, src_modem;

  assign ev_data     = push_ok && ier[IEN_DATA] && ((cnt8 + 8'd1) == trig_lvl);
  assign ev_line     = push_drop && ier[IEN_LINE];
  assign ev_en_empty = ier_wr && wdata[1] && empty;
  assign ev_drain    = pop_ok && (cnt8 == 8'd1) && ier[IEN_EMPTY];
  assign ev_modem    = mcr_wr && ier[IEN_MODEM] && (wdata[3] || wdata[1] || wdata[0]);
  assign ev_any      = ev_data || ev_line || ev_en_empty || ev_drain || ev_modem;

  assign src_line  = ier[IEN_LINE] && ovr;
  assign src_data  = ier[IEN_DATA] && (cnt8 >= trig_lvl);
  assign src_empty = ier[IEN_EMPTY] && empty;
  assign src_modem = ier[IEN_MODEM] && (mcr_lines != 2'b00);
  assign iir_val   = {4'b1100, iir_code(src_line, src_data, src_empty, src_modem)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= ev_any;
  end
endmodule

// File: rtl/lpbk_uart.sv
module lpbk_uart
  import lpbk_uart_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_pulse
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [3:0]       ier;
  logic [7:0]       lcr, mcr, scr, trig_lvl, iir_val, ring_dout, last_rx, cnt8;
  logic [15:0]      divisor;
  logic             fifo_on, dlab, clr_req;
  logic [CNT_W-1:0] count;
  logic             empty, at_cap, push_ok, push_drop, pop_ok, ovr;
  logic             rd_act, push_req, pop_req, ier_wr, mcr_wr, cts;

  assign rd_act   = reg_rd && !reg_wr;
  assign push_req = reg_wr && (reg_addr == OFS_DATA) && !dlab;
  assign pop_req  = rd_act && (reg_addr == OFS_DATA) && !dlab;
  assign ier_wr   = reg_wr && (reg_addr == OFS_IEN) && !dlab;
  assign mcr_wr   = reg_wr && (reg_addr == OFS_MCTL);
  assign cnt8     = 8'(count);
  assign cts      = !(mcr[5] && at_cap);

  lpbk_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ier(ier), .lcr(lcr), .mcr(mcr), .scr(scr), .divisor(divisor),
    .fifo_on(fifo_on), .trig_lvl(trig_lvl), .dlab(dlab), .clr_req(clr_req)
  );

  lpbk_ring #(.DEPTH(DEPTH), .DATA_W(BYTE_W), .CNT_W(CNT_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .clr(clr_req), .cap_one(!fifo_on), .din(reg_wdata), .dout(ring_dout),
    .count(count), .empty(empty), .at_cap(at_cap), .push_ok(push_ok),
    .push_drop(push_drop), .pop_ok(pop_ok), .ovr(ovr)
  );

  lpbk_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .ier(ier), .mcr_lines(mcr[1:0]), .cnt8(cnt8),
    .trig_lvl(trig_lvl), .empty(empty), .ovr(ovr), .push_ok(push_ok),
    .push_drop(push_drop), .pop_ok(pop_ok), .ier_wr(ier_wr), .mcr_wr(mcr_wr),
    .wdata(reg_wdata), .iir_val(iir_val), .irq_pulse(irq_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      last_rx   <= '0;
    end else begin
      if (pop_ok) last_rx <= ring_dout;
      if (rd_act) begin
        case (reg_addr)
          OFS_DATA:  reg_rdata <= dlab ? divisor[7:0] : (empty ? last_rx : ring_dout);
          OFS_IEN:   reg_rdata <= dlab ? divisor[15:8] : {4'b0000, ier};
          OFS_FCTL:  reg_rdata <= iir_val;
          OFS_LCTL:  reg_rdata <= lcr;
          OFS_MCTL:  reg_rdata <= mcr;
          OFS_LSTAT: reg_rdata <= lsr_pack(!empty, ovr);
          OFS_MSTAT: reg_rdata <= msr_pack(cts);
          default:   reg_rdata <= scr;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpbk_uart_chk.sv
module lpbk_uart_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic        push_ok,
  input logic        push_drop,
  input logic        pop_ok,
  input logic        ovr,
  input logic        empty,
  input logic        dlab,
  input logic        clr_req,
  input logic [7:0]  cnt8,
  input logic [15:0] divisor
);
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovr); // R4
  AST_PUSH_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> !ovr); // R4
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt8 <= 8'(DEPTH)); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> empty); // R5
  AST_DLAB_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[7]) |=> (divisor == 16'h0)); // R3
  AST_IIR_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == 3'd2) |=> (reg_rdata[7:6] == 2'b11)); // R10
  AST_IGNORED_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 3'd5 || reg_addr == 3'd6)) |=> ($stable(cnt8) && $stable(ovr))); // R7
  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == 3'd0 && !dlab && empty) |=> ($stable(cnt8) && $stable(ovr))); // R12
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_wr) |=> $stable(reg_rdata)); // R13
  AST_NO_POP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_wr) |-> !pop_ok); // R13
endmodule

bind lpbk_uart lpbk_uart_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_ok(push_ok),
  .push_drop(push_drop), .pop_ok(pop_ok), .ovr(ovr), .empty(empty), .dlab(dlab),
  .clr_req(clr_req), .cnt8(cnt8), .divisor(divisor)
);

// File: tb/lpbk_uart_tb_top.sv
module lpbk_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_pulse;

  int total = 0;
  int bad = 0;
  bit last_irq = 1'b0;
  bit rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  lpbk_uart dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse)
  );

  // monitor: a read accepted at an edge is compared at the following falling edge
  always @(posedge clk) rd_seen <= reg_rd && !reg_wr;

  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (rd_seen) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: unexpected read actual=%02h expected=none", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          bad++;
          $display("FAIL %s actual=%02h expected=%02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    last_irq = irq_pulse;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
    last_irq = irq_pulse;
  endtask

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    chk8({7'd0, last_irq}, {7'd0, exp}, tag);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk8(reg_rdata, 8'h00, "R1 rdata after reset");
    chk8({7'd0, irq_pulse}, 8'h00, "R1 irq after reset");
    rd(3'd5, 8'h60, "R1 LSR at reset");
    rd(3'd2, 8'hC1, "R1 IIR at reset");
    rd(3'd6, 8'hB3, "R8 MSR at reset");
    rd(3'd0, 8'h00, "R12 empty RX after reset");

    // R9 plain registers and enable masking
    wr(3'd7, 8'h5A);
    rd(3'd7, 8'h5A, "R9 scratch");
    wr(3'd1, 8'hFF);
    chk_irq(1'b1, "R11 enable THR empty while empty");
    rd(3'd1, 8'h0F, "R9 enable low nibble");
    rd(3'd2, 8'hC2, "R10 THR empty code");
    wr(3'd1, 8'h00);

    // R2 order
    wr(3'd0, 8'h11); wr(3'd0, 8'h22); wr(3'd0, 8'h33);
    rd(3'd5, 8'h01, "R7 LSR data ready");
    rd(3'd0, 8'h11, "R2 fifo order 0");
    rd(3'd0, 8'h22, "R2 fifo order 1");
    rd(3'd0, 8'h33, "R2 fifo order 2");
    rd(3'd5, 8'h60, "R7 LSR empty");

    // R2/R4/R8 full buffer with wrapped indices
    for (int i = 0; i < 16; i++) wr(3'd0, 8'(i * 3 + 1));
    rd(3'd5, 8'h01, "R7 LSR full");
    wr(3'd0, 8'hEE);
    rd(3'd5, 8'h03, "R4 overrun after drop");
    wr(3'd4, 8'h20);
    rd(3'd6, 8'hA2, "R8 MSR flow blocked at capacity");
    rd(3'd4, 8'h20, "R9 MCR readback");
    for (int i = 0; i < 16; i++) rd(3'd0, 8'(i * 3 + 1), "R2 wrapped drain");
    rd(3'd5, 8'h62, "R4 pops keep overrun");
    wr(3'd0, 8'h44);
    rd(3'd5, 8'h01, "R4 push clears overrun");
    rd(3'd6, 8'hB3, "R8 MSR with room");
    rd(3'd0, 8'h44, "R2 single");
    wr(3'd4, 8'h00);
    rd(3'd0, 8'h44, "R12 empty RX returns last");
    rd(3'd5, 8'h60, "R12 empty RX no state change");

    // R3 divisor access
    wr(3'd0, 8'h77);
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, 8'h34, "R3 divisor low");
    rd(3'd1, 8'h12, "R3 divisor high");
    rd(3'd3, 8'h83, "R9 LCR readback");
    wr(3'd3, 8'h03);
    rd(3'd3, 8'h03, "R9 LCR readback 2");
    rd(3'd1, 8'h00, "R3 enables untouched");
    rd(3'd5, 8'h01, "R3 buffer untouched");
    rd(3'd0, 8'h77, "R3 buffer byte intact");
    wr(3'd3, 8'h80);
    rd(3'd0, 8'h00, "R3 divisor cleared low");
    rd(3'd1, 8'h00, "R3 divisor cleared high");
    wr(3'd3, 8'h00);

    // R5 capacity and clears
    wr(3'd2, 8'h00);
    wr(3'd0, 8'hA1);
    wr(3'd0, 8'hA2);
    rd(3'd5, 8'h03, "R5 capacity one drops second");
    rd(3'd0, 8'hA1, "R5 capacity one keeps first");
    rd(3'd5, 8'h62, "R5 empty with overrun");
    wr(3'd2, 8'h01);
    for (int i = 0; i < 5; i++) wr(3'd0, 8'(8'h10 + i));
    wr(3'd2, 8'h03);
    rd(3'd5, 8'h60, "R5 clear via bit 1");
    wr(3'd0, 8'h20);
    wr(3'd2, 8'h05);
    rd(3'd5, 8'h60, "R5 clear via bit 2");
    rd(3'd0, 8'hA1, "R12 cleared buffer returns last popped");

    // R6 trigger levels
    wr(3'd2, 8'h41);
    wr(3'd1, 8'h01);
    chk_irq(1'b0, "R11 enable write without THR bit");
    wr(3'd0, 8'h30); wr(3'd0, 8'h31); wr(3'd0, 8'h32);
    chk_irq(1'b0, "R6 below level 4");
    rd(3'd2, 8'hC1, "R6 level 4 not reached");
    wr(3'd0, 8'h33);
    chk_irq(1'b1, "R6 level 4 reached");
    rd(3'd2, 8'hC4, "R10 data available code");
    wr(3'd0, 8'h34);
    chk_irq(1'b0, "R11 no pulse past level");
    wr(3'd2, 8'h83);
    for (int i = 0; i < 7; i++) wr(3'd0, 8'(i));
    chk_irq(1'b0, "R6 seventh push level 8");
    wr(3'd0, 8'h07);
    chk_irq(1'b1, "R6 level 8 reached");
    wr(3'd2, 8'hC3);
    for (int i = 0; i < 13; i++) wr(3'd0, 8'(i));
    chk_irq(1'b0, "R6 thirteenth push level 14");
    wr(3'd0, 8'h0D);
    chk_irq(1'b1, "R6 level 14 reached");
    rd(3'd2, 8'hC4, "R10 data available at 14");
    wr(3'd2, 8'hC2);
    wr(3'd0, 8'h66);
    chk_irq(1'b1, "R6 fifo off forces level 1");

    // R10/R11 priority walk
    wr(3'd1, 8'h0F);
    chk_irq(1'b0, "R11 THR enable while non-empty");
    wr(3'd0, 8'h67);
    chk_irq(1'b1, "R11 drop with line enable");
    rd(3'd2, 8'hC6, "R10 line status highest");
    rd(3'd0, 8'h66, "R2 capacity one pop");
    chk_irq(1'b1, "R11 pop empties buffer");
    rd(3'd2, 8'hC6, "R10 line status over THR empty");
    wr(3'd0, 8'h55);
    chk_irq(1'b1, "R11 push reaches level 1");
    rd(3'd2, 8'hC4, "R10 data after overrun cleared");
    rd(3'd0, 8'h55, "R2 pop 55");
    chk_irq(1'b1, "R11 drain pulse");
    rd(3'd2, 8'hC2, "R10 THR empty");
    wr(3'd1, 8'h08);
    chk_irq(1'b0, "R11 modem enable alone");
    wr(3'd4, 8'h02);
    chk_irq(1'b1, "R11 RTS write with modem enable");
    rd(3'd2, 8'hC0, "R10 modem status code");
    wr(3'd4, 8'h00);
    chk_irq(1'b0, "R11 MCR zero write");
    rd(3'd2, 8'hC1, "R10 nothing pending");
    wr(3'd4, 8'h08);
    chk_irq(1'b1, "R11 OUT2 write");
    rd(3'd2, 8'hC1, "R10 OUT2 not a source");
    wr(3'd4, 8'h00);
    wr(3'd1, 8'h00);

    // R13 write wins
    wr(3'd2, 8'h07);
    held = reg_rdata;
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 8'h99; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk8(reg_rdata, held, "R13 rdata held on collision");
    rd(3'd5, 8'h01, "R13 write taken");
    rd(3'd0, 8'h99, "R13 pushed byte");

    // R7 ignored writes
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'h00);
    rd(3'd5, 8'h60, "R7 LSR write ignored");
    rd(3'd6, 8'hB3, "R7 MSR write ignored");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
    end
    summary();
  end
endmodule